// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a general-purpose I/O controller for a parameterized number of pins. The pin count is a multiple of 32, with 64 and 96 as the intended sizes. A plain 32-bit register port gives software control of the pins. The port has a byte address, a write strobe, write data and combinational read data. The pins are split into banks of 32. For each pin, software can:

- choose whether the pin is driven;
- raise or lower its output through separate write-only set and clear words;
- read the synchronized input level;
- arm capture of rising edges, falling edges or both;
- acknowledge captured edges by writing ones to them;
- choose a two-bit alternate-function code.

Each pin input passes through a two-stage synchronizer before anything reads it. One level-sensitive interrupt line stays high while any captured-edge bit is set. Masking, pad circuits and bus bridging are left to the surrounding logic.

The map holds eight register kinds. Each kind is an array of `NUM_PINS/32` words, except the alternate-function array, which is twice that size. Word `k*NB + b` (where NB = `NUM_PINS/32`) holds kind `k` for bank `b`. The kinds take indices in this order: 0 level, 1 drive enable, 2 set, 3 clear, 4 rise arm, 5 fall arm, 6 captured edges, 7 alternate function.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: A word at byte address `(k*NB + b)*4` controls kind `k` of bank `b`, and bit `i` of that word belongs to pin `b*32+i`. The kind indices are: level 0, drive enable 1, set 2, clear 3, rise arm 4, fall arm 5, captured edges 6, alternate function 7.
- R2: The drive-enable word reads back as written, and `pin_oe[p]` equals its bit. A 1 means the pin is driven and a 0 means it is an input.
- R3: Writing a 1 to a bit of a set word makes `pin_out` for that pin 1 from the next clock. Zero bits change nothing, and the set word reads as 0.
- R4: Writing a 1 to a bit of a clear word makes `pin_out` for that pin 0 from the next clock. Zero bits change nothing, and the clear word reads as 0.
- R5: The level word returns `pin_in` after two clock edges of synchronization. Writes to a level word are ignored.
- R6: With the rise-arm bit set, a 0-to-1 change on the pin sets its captured-edge bit on the third clock edge after the change. With the bit clear, a rising change sets nothing.
- R7: Rise and fall arming are independent. With only fall armed, a 1-to-0 change is captured and a 0-to-1 change is not. With both armed, either change is captured.
- R8: Writing 1 to a captured-edge bit clears it, and writing 0 leaves it set. If an armed edge is detected in the same cycle as the clearing write, the bit stays set.
- R9: Alternate-function word `j` sits at byte address `(7*NB + j)*4`, with `2*NB` such words. Pin `p` uses bits `[(p%16)*2+1 : (p%16)*2]` of word `p/16`, and `pin_af[2p+1:2p]` equals that field. Code 0 means plain GPIO.
- R10: `irq` is high exactly while at least one captured-edge bit is set, with no added delay.
- R11: After reset, all of the following are zero: drive enables, outputs, arm bits, captured edges, alternate-function codes and `irq`.
- R12: An address beyond the map, or one with non-zero low two bits, reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Drive enables, 1 = driven |
| pin_af | output | 2*NUM_PINS | Alternate-function codes, two bits per pin |
| irq | output | 1 | High while any captured-edge bit is set |

## Verification
A register write takes effect at the clock edge that samples it. The bench therefore checks `pin_out`, `pin_oe`, `pin_af` and readback at the falling edge after that edge. Read data is combinational, so it is sampled one nanosecond after the address is applied.

A pin change is applied at a falling edge. The level readback is checked after exactly one rising edge, where it must still show the old value, and after the second rising edge, where it must show the new one. The captured-edge bit and `irq` are checked as clear after two rising edges and as set after the third.

For the coincidence case, the clearing write is timed so that the edge sampling it is that third edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int WORD_W     = 32;
    localparam int BANK_PINS  = 32;
    localparam int AF_BITS    = 2;
    localparam int AF_PER_WORD = WORD_W / AF_BITS;
    localparam int NUM_KINDS  = 8;

    // Order of the register arrays in the map; the decode depends on it.
    typedef enum logic [2:0] {
        K_LEVEL = 3'd0,
        K_DRIVE = 3'd1,
        K_SET   = 3'd2,
        K_CLR   = 3'd3,
        K_RISE  = 3'd4,
        K_FALL  = 3'd5,
        K_EDGE  = 3'd6,
        K_ALT   = 3'd7
    } reg_kind_e;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stab;

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
    import gpio_edge_pkg::*;
#(
    parameter int W = BANK_PINS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    input  logic         wr_drive,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic         wr_rise,
    input  logic         wr_fall,
    input  logic         wr_edge,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] drive_o,
    output logic [W-1:0] out_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o,
    output logic [W-1:0] edge_o
);

    typedef struct packed {
        logic [W-1:0] drive;
        logic [W-1:0] outv;
        logic [W-1:0] rise;
        logic [W-1:0] fall;
        logic [W-1:0] caught;
        logic [W-1:0] prev;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [W-1:0] hit;
    logic [W-1:0] kept;

    always_comb begin
        bk_d      = bk_q;
        bk_d.prev = lvl_in;

        hit  = (lvl_in & ~bk_q.prev & bk_q.rise)
             | (~lvl_in & bk_q.prev & bk_q.fall);

        if (wr_drive) bk_d.drive = wdata;
        if (wr_set)   bk_d.outv  = bk_q.outv | wdata;
        if (wr_clr)   bk_d.outv  = bk_q.outv & ~wdata;
        if (wr_rise)  bk_d.rise  = wdata;
        if (wr_fall)  bk_d.fall  = wdata;

        kept = wr_edge ? (bk_q.caught & ~wdata) : bk_q.caught;
        // A fresh edge wins over an acknowledge in the same cycle.
        bk_d.caught = kept | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign drive_o = bk_q.drive;
    assign out_o   = bk_q.outv;
    assign rise_o  = bk_q.rise;
    assign fall_o  = bk_q.fall;
    assign edge_o  = bk_q.caught;

endmodule

// File: rtl/gpio_altfn_regs.sv
module gpio_altfn_regs
    import gpio_edge_pkg::*;
#(
    parameter int NWORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NWORDS-1:0]        wr_sel,
    input  logic [WORD_W-1:0]        wdata,
    output logic [NWORDS*WORD_W-1:0] af_flat
);

    typedef struct packed {
        logic [NWORDS*WORD_W-1:0] codes;
    } af_t;

    af_t af_d, af_q;

    always_comb begin
        af_d = af_q;
        for (int j = 0; j < NWORDS; j++) begin
            if (wr_sel[j]) af_d.codes[j*WORD_W +: WORD_W] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            af_q <= '0;
        end else begin
            af_q <= af_d;
        end
    end

    assign af_flat = af_q.codes;

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [2*NUM_PINS-1:0] pin_af,
    output logic                  irq
);

    localparam int NB       = NUM_PINS / BANK_PINS;
    localparam int AF_WORDS = (NUM_PINS * AF_BITS) / WORD_W;
    localparam int IDX_W    = ADDR_W - 2;
    localparam int AF_BASE  = int'(K_ALT) * NB;

    logic [IDX_W-1:0]             widx;
    logic                         aligned;
    logic                         wr_ok;
    logic [NUM_PINS-1:0]          lvl_all;
    logic [NB-1:0][WORD_W-1:0]    drive_w, out_w, rise_w, fall_w, edge_w;
    logic [NB-1:0][NUM_KINDS-1:1] wsel;
    logic [AF_WORDS-1:0]          af_sel;
    logic [AF_WORDS*WORD_W-1:0]   af_flat;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_wr && aligned;

    gpio_sync2 #(.W(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl_all)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        for (genvar k = 1; k < NUM_KINDS - 1; k++) begin : g_sel
            assign wsel[b][k] = wr_ok && (widx == IDX_W'(k * NB + b));
        end
        assign wsel[b][NUM_KINDS-1] = 1'b0;

        gpio_pin_bank #(.W(BANK_PINS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_in   (lvl_all[b*BANK_PINS +: BANK_PINS]),
            .wr_drive (wsel[b][int'(K_DRIVE)]),
            .wr_set   (wsel[b][int'(K_SET)]),
            .wr_clr   (wsel[b][int'(K_CLR)]),
            .wr_rise  (wsel[b][int'(K_RISE)]),
            .wr_fall  (wsel[b][int'(K_FALL)]),
            .wr_edge  (wsel[b][int'(K_EDGE)]),
            .wdata    (bus_wdata),
            .drive_o  (drive_w[b]),
            .out_o    (out_w[b]),
            .rise_o   (rise_w[b]),
            .fall_o   (fall_w[b]),
            .edge_o   (edge_w[b])
        );
    end

    for (genvar j = 0; j < AF_WORDS; j++) begin : g_afsel
        assign af_sel[j] = wr_ok && (widx == IDX_W'(AF_BASE + j));
    end

    gpio_altfn_regs #(.NWORDS(AF_WORDS)) u_altfn (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (af_sel),
        .wdata   (bus_wdata),
        .af_flat (af_flat)
    );

    // Read mux: at most one word index matches; set and clear read as zero.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            for (int b = 0; b < NB; b++) begin
                if (widx == IDX_W'(int'(K_LEVEL) * NB + b)) bus_rdata = lvl_all[b*BANK_PINS +: BANK_PINS];
                if (widx == IDX_W'(int'(K_DRIVE) * NB + b)) bus_rdata = drive_w[b];
                if (widx == IDX_W'(int'(K_RISE)  * NB + b)) bus_rdata = rise_w[b];
                if (widx == IDX_W'(int'(K_FALL)  * NB + b)) bus_rdata = fall_w[b];
                if (widx == IDX_W'(int'(K_EDGE)  * NB + b)) bus_rdata = edge_w[b];
            end
            for (int j = 0; j < AF_WORDS; j++) begin
                if (widx == IDX_W'(AF_BASE + j)) bus_rdata = af_flat[j*WORD_W +: WORD_W];
            end
        end
    end

    assign pin_out = out_w;
    assign pin_oe  = drive_w;
    assign pin_af  = af_flat;
    assign irq     = |edge_w;

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic [31:0]           bus_wdata,
    input logic [NUM_PINS-1:0]   pin_out,
    input logic [NUM_PINS-1:0]   pin_oe,
    input logic [2*NUM_PINS-1:0] pin_af,
    input logic                  irq
);

    localparam int NB = NUM_PINS / 32;
    localparam logic [ADDR_W-1:0] SET0_A = ADDR_W'(2 * NB * 4);
    localparam logic [ADDR_W-1:0] CLR0_A = ADDR_W'(3 * NB * 4);

    // R3: a set write to bank 0 forces the written ones high
    a_r3_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SET0_A) |=> ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R4: a clear write to bank 0 forces the written ones low
    a_r4_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CLR0_A) |=> ((pin_out[31:0] & $past(bus_wdata)) == 32'd0));

    // R3: outputs move only through writes
    a_r3_out_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_out));

    // R2: drive enables move only through writes
    a_r2_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_oe));

    // R9: alternate-function codes move only through writes
    a_r9_af_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_af));

    // R10/R8: the interrupt can only drop after an acknowledging write
    a_r10_irq_drop_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr));

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_af    (pin_af),
    .irq       (irq)
);

// File: tb/gpio_edge_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_bench;

    localparam int NP = 64;
    localparam int AW = 8;
    localparam int NB = NP / 32;
    localparam int AFW = 2 * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [2*NP-1:0] pin_af;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_af(pin_af), .irq(irq)
    );

    function automatic logic [AW-1:0] ad(int kind, int word);
        return AW'((kind * NB + word) * 4);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_now(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [NP-1:0] mdl;
        logic [31:0] afm [AFW];

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk(pin_oe == '0, "R11 oe", pin_oe, 0);
        chk(pin_out == '0, "R11 out", pin_out, 0);
        chk(pin_af == '0, "R11 af", pin_af, 0);
        chk(irq == 1'b0, "R11 irq", irq, 0);
        for (int w = 0; w < 9 * NB; w++) begin
            rd_now(AW'(w * 4), r);
            chk(r == 32'd0, "R11 word", r, 0);
        end

        // R2 / R1: drive enables, one pin at a time
        for (int p = 0; p < NP; p++) begin
            wr(ad(1, p / 32), 32'd1 << (p % 32));
            chk(pin_oe == (64'd1 << p), "R2 R1 oe", pin_oe, 64'd1 << p);
            rd_now(ad(1, p / 32), r);
            chk(r == (32'd1 << (p % 32)), "R2 readback", r, 32'd1 << (p % 32));
            wr(ad(1, p / 32), 32'd0);
        end
        chk(pin_oe == '0, "R2 cleared", pin_oe, 0);

        // R3: set pin by pin, zero bits no effect, set word reads zero
        mdl = '0;
        for (int p = 0; p < NP; p++) begin
            wr(ad(2, p / 32), 32'd1 << (p % 32));
            mdl[p] = 1'b1;
            chk(pin_out == mdl, "R3 set", pin_out, mdl);
        end
        wr(ad(2, 0), 32'd0);
        chk(pin_out == mdl, "R3 zero write", pin_out, mdl);
        rd_now(ad(2, 1), r);
        chk(r == 32'd0, "R3 reads zero", r, 0);

        // R4: clear every third pin, then the rest
        for (int p = 0; p < NP; p += 3) begin
            wr(ad(3, p / 32), 32'd1 << (p % 32));
            mdl[p] = 1'b0;
            chk(pin_out == mdl, "R4 clear", pin_out, mdl);
        end
        wr(ad(3, 1), 32'd0);
        chk(pin_out == mdl, "R4 zero write", pin_out, mdl);
        rd_now(ad(3, 0), r);
        chk(r == 32'd0, "R4 reads zero", r, 0);
        wr(ad(3, 0), 32'hFFFF_FFFF);
        wr(ad(3, 1), 32'hFFFF_FFFF);
        chk(pin_out == '0, "R4 clear all", pin_out, 0);

        // R5: level readback latency of two edges, walking one
        for (int p = 0; p < NP; p++) begin
            logic [NP-1:0] prev;
            prev = pin_in;
            set_pins(64'd1 << p);
            tick(1);
            rd_now(ad(0, p / 32), r);
            chk(r == prev[(p / 32) * 32 +: 32], "R5 one edge old", r, prev[(p / 32) * 32 +: 32]);
            tick(0);
            @(posedge clk);
            @(negedge clk);
            rd_now(ad(0, p / 32), r);
            chk(r == (32'd1 << (p % 32)), "R5 two edges new", r, 32'd1 << (p % 32));
        end
        wr(ad(0, 1), 32'h0000_FFFF);
        rd_now(ad(0, 1), r);
        chk(r == 32'h8000_0000, "R5 write ignored", r, 32'h8000_0000);
        set_pins('0);
        tick(3);

        // R6 / R7 / R8 / R10: per pin edge capture
        for (int p = 0; p < NP; p++) begin
            logic [AW-1:0] ea;
            logic [31:0] bit_m;
            ea = ad(6, p / 32);
            bit_m = 32'd1 << (p % 32);
            // fall only: rising ignored, falling caught
            wr(ad(5, p / 32), bit_m);
            set_pins(64'd1 << p);
            tick(3);
            rd_now(ea, r);
            chk(r == 32'd0, "R7 rise ignored", r, 0);
            set_pins('0);
            tick(3);
            rd_now(ea, r);
            chk(r == bit_m, "R7 fall caught", r, bit_m);
            wr(ea, bit_m);
            wr(ad(5, p / 32), 32'd0);
            // rise only with latency
            wr(ad(4, p / 32), bit_m);
            set_pins(64'd1 << p);
            tick(2);
            rd_now(ea, r);
            chk(r == 32'd0 && !irq, "R6 not yet", {r, 31'd0, irq}, 0);
            tick(1);
            rd_now(ea, r);
            chk(r == bit_m, "R6 caught", r, bit_m);
            chk(irq == 1'b1, "R10 irq high", irq, 1);
            wr(ea, 32'd0);
            rd_now(ea, r);
            chk(r == bit_m, "R8 zero keeps", r, bit_m);
            wr(ea, bit_m);
            rd_now(ea, r);
            chk(r == 32'd0 && !irq, "R8 R10 cleared", {r, 31'd0, irq}, 0);
            set_pins('0);
            tick(3);
            rd_now(ea, r);
            chk(r == 32'd0, "R6 fall ignored", r, 0);
            wr(ad(4, p / 32), 32'd0);
        end

        // R7: both edges armed on pin 5
        wr(ad(4, 0), 32'h20);
        wr(ad(5, 0), 32'h20);
        set_pins(64'h20);
        tick(3);
        rd_now(ad(6, 0), r);
        chk(r == 32'h20, "R7 both rise", r, 32'h20);
        wr(ad(6, 0), 32'h20);
        set_pins('0);
        tick(3);
        rd_now(ad(6, 0), r);
        chk(r == 32'h20, "R7 both fall", r, 32'h20);
        wr(ad(6, 0), 32'h20);
        wr(ad(4, 0), 32'd0);
        wr(ad(5, 0), 32'd0);

        // R8: edge in the same cycle as the clearing write (pin 40)
        wr(ad(4, 1), 32'h100);
        set_pins(64'd1 << 40);
        tick(3);
        set_pins('0);
        tick(3);
        rd_now(ad(6, 1), r);
        chk(r == 32'h100, "R8 pre set", r, 32'h100);
        set_pins(64'd1 << 40);
        @(posedge clk);
        @(posedge clk);
        wr(ad(6, 1), 32'h100);
        rd_now(ad(6, 1), r);
        chk(r == 32'h100, "R8 coincident kept", r, 32'h100);
        chk(irq == 1'b1, "R8 irq kept", irq, 1);
        wr(ad(6, 1), 32'h100);
        rd_now(ad(6, 1), r);
        chk(r == 32'd0, "R8 later clear", r, 0);
        wr(ad(4, 1), 32'd0);
        set_pins('0);
        tick(3);

        // R9: alternate-function codes
        for (int j = 0; j < AFW; j++) afm[j] = '0;
        for (int p = 0; p < NP; p++) begin
            logic [1:0] v;
            logic [2*NP-1:0] flat;
            v = 2'((p + 1) % 4);
            afm[p / 16][(p % 16) * 2 +: 2] = v;
            wr(ad(7, p / 16), afm[p / 16]);
            flat = {afm[3], afm[2], afm[1], afm[0]};
            chk(pin_af[2 * p +: 2] == v, "R9 field", pin_af[2 * p +: 2], v);
            chk(pin_af == flat, "R9 all", pin_af, flat);
            rd_now(ad(7, p / 16), r);
            chk(r == afm[p / 16], "R9 readback", r, afm[p / 16]);
        end

        // R12: unmapped and misaligned addresses
        wr(ad(1, 1), 32'h0000_00F0);
        wr(AW'(9 * NB * 4), 32'hFFFF_FFFF);
        wr(AW'(252), 32'hFFFF_FFFF);
        wr(ad(1, 0) + AW'(1), 32'hFFFF_FFFF);
        wr(ad(2, 0) + AW'(2), 32'hFFFF_FFFF);
        chk(pin_oe == (64'hF0 << 32), "R12 oe kept", pin_oe, 64'hF0 << 32);
        chk(pin_out == '0, "R12 out kept", pin_out, 0);
        rd_now(AW'(9 * NB * 4), r);
        chk(r == 32'd0, "R12 unmapped read", r, 0);
        rd_now(ad(1, 1) + AW'(1), r);
        chk(r == 32'd0, "R12 misaligned read", r, 0);
        rd_now(ad(1, 1), r);
        chk(r == 32'hF0, "R1 bank1 drive", r, 32'hF0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule